// File: doc/BRIEF.md
# SIMT Instruction Stream Tracker

This block keeps, for every warp of a SIMT core, the set of instruction streams that the warp's threads currently follow. A stream is a common PC, a call depth and a thread mask. Bit i of the mask marks thread i of the warp as a member. The two highest-ranked streams of each warp sit in two hot tables indexed by warp number: the active stream and the second stream. All other streams sit in a per-warp cold stack. The cold stack has room for one stream per thread.

When an instruction commits for a warp, the block produces the commit mask and the leader thread. It then takes the warp's second stream, the fall-through stream and the taken (or replay) stream as candidates. It merges candidates that share a PC and depth, discards empty ones and ranks the rest. Rank goes first to the deeper call level, then to the lower PC. The best candidate becomes the active stream and the next becomes the second stream. A third candidate is pushed onto the cold stack. If only one candidate survives, the second stream is refilled from the cold stack. A background sorter walks each warp's cold stack whenever that warp is not committing, and swaps any cold entry that outranks the second stream into the hot table.

Top module: `simt_stream_tracker`

## Requirements
- R1: After reset, every warp has active stream (RESET_PC, depth 0, all threads set), an empty second stream (mask 0) and an empty cold stack.
- R2: The commit mask equals the active mask of `commit_warp_i` when `commit_valid_i` is high, `commit_pc_i` equals the active PC and that mask is nonzero. Otherwise the commit mask is 0, and a commit with a zero commit mask changes no stream.
- R3: `leader_o` is the index of the lowest set bit of the commit mask, and `leader_valid_o` is high exactly when the commit mask is nonzero.
- R4: Candidates with equal PC and equal depth are merged by ORing their masks. Candidates with a zero mask are discarded. The fall-through and taken masks are ANDed with the commit mask.
- R5: Candidates are ranked deeper depth first, then lower PC. The best becomes the active stream and the second best becomes the second stream.
- R6: When one candidate survives, the second stream is popped from the head of the warp's cold stack, or becomes empty if that stack is empty.
- R7: When three candidates survive, the third is pushed onto the head of the warp's cold stack.
- R8: When a warp has no commit, the background sorter swaps a cold entry with the warp's second stream if the cold entry outranks it. It never swaps for a warp that is committing in the same cycle.
- R9: No thread belongs to two hot streams, every hot stream's PC and depth match the per-thread state of its members, and no thread is ever lost.
- R10: `query_warp_i` selects the warp whose active and second streams appear combinationally on the `act_*` and `sec_*` outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| commit_valid_i | input | 1 | An instruction commits this cycle |
| commit_warp_i | input | WW | Warp of the committing instruction |
| commit_pc_i | input | PCW | Address of the committing instruction |
| seq_pc_i | input | PCW | Fall-through stream PC |
| seq_dep_i | input | DPW | Fall-through stream depth |
| seq_mask_i | input | NT | Fall-through stream threads |
| alt_pc_i | input | PCW | Taken or replay stream PC |
| alt_dep_i | input | DPW | Taken or replay stream depth |
| alt_mask_i | input | NT | Taken or replay stream threads |
| commit_mask_o | output | NT | Threads that commit |
| leader_o | output | TW | Leader thread index |
| leader_valid_o | output | 1 | Commit mask nonzero |
| query_warp_i | input | WW | Warp shown on the query outputs |
| act_pc_o | output | PCW | Active stream PC |
| act_dep_o | output | DPW | Active stream depth |
| act_mask_o | output | NT | Active stream threads |
| sec_pc_o | output | PCW | Second stream PC |
| sec_dep_o | output | DPW | Second stream depth |
| sec_mask_o | output | NT | Second stream threads |

## Verification
The hardest state to reach from the ports is a cold entry that outranks the second stream. Pushes always put the lowest-ranked candidate on the stack, so this state only appears after the second stream is later replaced by something ranked below an older cold entry. A directed sequence builds it in three commits and then leaves the warp idle, so that the sorter swap shows up on the second-stream outputs. Long random divergence runs are compared against a per-thread PC model. A final drain sends every stream to one common PC, which shows that cold entries still hidden on the stack carry every thread back.

// File: rtl/simt_trk_pkg.sv
package simt_trk_pkg;

  typedef enum logic [1:0] {
    SRT_IDLE = 2'd0,
    SRT_CMP  = 2'd1,
    SRT_SWAP = 2'd2
  } srt_state_e;

  // a outranks b: deeper call level first, then lower PC
  function automatic logic outranks(input int unsigned dep_a, input int unsigned pc_a,
                                    input int unsigned dep_b, input int unsigned pc_b);
    return (dep_a > dep_b) || ((dep_a == dep_b) && (pc_a < pc_b));
  endfunction

endpackage

// File: rtl/simt_trk_compact.sv
module simt_trk_compact
  import simt_trk_pkg::*;
#(
  parameter int unsigned NT  = 4,
  parameter int unsigned PCW = 16,
  parameter int unsigned DPW = 3
) (
  input  logic [PCW-1:0] c_pc_i   [3],
  input  logic [DPW-1:0] c_dep_i  [3],
  input  logic [NT-1:0]  c_mask_i [3],
  output logic [PCW-1:0] s_pc_o   [3],
  output logic [DPW-1:0] s_dep_o  [3],
  output logic [NT-1:0]  s_mask_o [3],
  output logic [1:0]     cnt_o
);

  logic [PCW-1:0] pc_v [3];
  logic [DPW-1:0] dp_v [3];
  logic [NT-1:0]  mk_v [3];
  logic [PCW-1:0] t_pc;
  logic [DPW-1:0] t_dp;
  logic [NT-1:0]  t_mk;
  int unsigned    a;

  always_comb begin
    for (int i = 0; i < 3; i++) begin
      pc_v[i] = c_pc_i[i];
      dp_v[i] = c_dep_i[i];
      mk_v[i] = c_mask_i[i];
    end
    // merge equal keys into the earlier slot
    for (int i = 0; i < 3; i++) begin
      for (int j = i + 1; j < 3; j++) begin
        if (mk_v[i] != '0 && mk_v[j] != '0 && pc_v[i] == pc_v[j] && dp_v[i] == dp_v[j]) begin
          mk_v[i] = mk_v[i] | mk_v[j];
          mk_v[j] = '0;
        end
      end
    end
    // three-comparator network, empty slots sink
    t_pc = '0;
    t_dp = '0;
    t_mk = '0;
    a    = 0;
    for (int k = 0; k < 3; k++) begin
      a = (k == 1) ? 1 : 0;
      if (mk_v[a+1] != '0 && (mk_v[a] == '0 ||
          outranks(32'(dp_v[a+1]), 32'(pc_v[a+1]), 32'(dp_v[a]), 32'(pc_v[a])))) begin
        t_pc = pc_v[a]; t_dp = dp_v[a]; t_mk = mk_v[a];
        pc_v[a] = pc_v[a+1]; dp_v[a] = dp_v[a+1]; mk_v[a] = mk_v[a+1];
        pc_v[a+1] = t_pc; dp_v[a+1] = t_dp; mk_v[a+1] = t_mk;
      end
    end
    for (int i = 0; i < 3; i++) begin
      s_pc_o[i]   = pc_v[i];
      s_dep_o[i]  = dp_v[i];
      s_mask_o[i] = mk_v[i];
    end
    cnt_o = {1'b0, (mk_v[0] != '0)} + {1'b0, (mk_v[1] != '0)} + {1'b0, (mk_v[2] != '0)};
  end

endmodule

// File: rtl/simt_trk_leader.sv
module simt_trk_leader #(
  parameter int unsigned NT = 4,
  parameter int unsigned TW = 2
) (
  input  logic [NT-1:0] mask_i,
  output logic [TW-1:0] idx_o,
  output logic          vld_o
);

  always_comb begin
    idx_o = '0;
    for (int i = NT - 1; i >= 0; i--) begin
      if (mask_i[i]) idx_o = TW'(i);
    end
    vld_o = |mask_i;
  end

endmodule

// File: rtl/simt_trk_sorter.sv
module simt_trk_sorter
  import simt_trk_pkg::*;
#(
  parameter int unsigned NW  = 4,
  parameter int unsigned NT  = 4,
  parameter int unsigned PCW = 16,
  parameter int unsigned DPW = 3,
  parameter int unsigned WW  = 2,
  parameter int unsigned TW  = 2,
  parameter int unsigned CW  = 3
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [CW-1:0]  cnt_i     [NW],
  input  logic [PCW-1:0] h2_pc_i   [NW],
  input  logic [DPW-1:0] h2_dep_i  [NW],
  input  logic [NT-1:0]  h2_mask_i [NW],
  input  logic [PCW-1:0] cd_pc_i   [NW][NT],
  input  logic [DPW-1:0] cd_dep_i  [NW][NT],
  input  logic           upd_i,
  input  logic [WW-1:0]  upd_warp_i,
  output logic           swap_o,
  output logic [WW-1:0]  swap_warp_o,
  output logic [TW-1:0]  swap_idx_o
);

  srt_state_e    state_q;
  logic [WW-1:0] sw_q, sw_nxt;
  logic [CW-1:0] ptr_q [NW];
  logic [TW-1:0] idx;
  logic          yield, better;

  assign sw_nxt = (sw_q == WW'(NW - 1)) ? '0 : sw_q + 1'b1;
  assign idx    = ptr_q[sw_q][TW-1:0];
  assign yield  = upd_i && (upd_warp_i == sw_q);
  assign better = (h2_mask_i[sw_q] != '0) &&
                  outranks(32'(cd_dep_i[sw_q][idx]), 32'(cd_pc_i[sw_q][idx]),
                           32'(h2_dep_i[sw_q]), 32'(h2_pc_i[sw_q]));

  assign swap_o      = (state_q == SRT_SWAP) && !yield;
  assign swap_warp_o = sw_q;
  assign swap_idx_o  = idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SRT_IDLE;
      sw_q    <= '0;
      for (int w = 0; w < NW; w++) ptr_q[w] <= '0;
    end else begin
      unique case (state_q)
        SRT_IDLE: begin
          if (cnt_i[sw_q] != '0) state_q <= SRT_CMP;
          else                   sw_q    <= sw_nxt;
        end
        SRT_CMP: begin
          if (yield) begin
            state_q <= SRT_IDLE;
            sw_q    <= sw_nxt;
          end else if (ptr_q[sw_q] >= cnt_i[sw_q]) begin
            ptr_q[sw_q] <= '0;
            state_q     <= SRT_IDLE;
            sw_q        <= sw_nxt;
          end else if (better) begin
            state_q <= SRT_SWAP;
          end else begin
            ptr_q[sw_q] <= ptr_q[sw_q] + 1'b1;
            state_q     <= SRT_IDLE;
            sw_q        <= sw_nxt;
          end
        end
        default: begin
          if (!yield) ptr_q[sw_q] <= ptr_q[sw_q] + 1'b1;
          state_q <= SRT_IDLE;
          sw_q    <= sw_nxt;
        end
      endcase
    end
  end

endmodule

// File: rtl/simt_stream_tracker.sv
module simt_stream_tracker
  import simt_trk_pkg::*;
#(
  parameter int unsigned NW       = 4,
  parameter int unsigned NT       = 4,
  parameter int unsigned PCW      = 16,
  parameter int unsigned DPW      = 3,
  parameter int unsigned RESET_PC = 0,
  localparam int unsigned WW      = (NW > 1) ? $clog2(NW) : 1,
  localparam int unsigned TW      = (NT > 1) ? $clog2(NT) : 1,
  localparam int unsigned CW      = $clog2(NT + 1)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           commit_valid_i,
  input  logic [WW-1:0]  commit_warp_i,
  input  logic [PCW-1:0] commit_pc_i,
  input  logic [PCW-1:0] seq_pc_i,
  input  logic [DPW-1:0] seq_dep_i,
  input  logic [NT-1:0]  seq_mask_i,
  input  logic [PCW-1:0] alt_pc_i,
  input  logic [DPW-1:0] alt_dep_i,
  input  logic [NT-1:0]  alt_mask_i,
  output logic [NT-1:0]  commit_mask_o,
  output logic [TW-1:0]  leader_o,
  output logic           leader_valid_o,
  input  logic [WW-1:0]  query_warp_i,
  output logic [PCW-1:0] act_pc_o,
  output logic [DPW-1:0] act_dep_o,
  output logic [NT-1:0]  act_mask_o,
  output logic [PCW-1:0] sec_pc_o,
  output logic [DPW-1:0] sec_dep_o,
  output logic [NT-1:0]  sec_mask_o
);

  logic [PCW-1:0] h1_pc   [NW];
  logic [DPW-1:0] h1_dep  [NW];
  logic [NT-1:0]  h1_mask [NW];
  logic [PCW-1:0] h2_pc   [NW];
  logic [DPW-1:0] h2_dep  [NW];
  logic [NT-1:0]  h2_mask [NW];
  logic [PCW-1:0] cd_pc   [NW][NT];
  logic [DPW-1:0] cd_dep  [NW][NT];
  logic [NT-1:0]  cd_mask [NW][NT];
  logic [CW-1:0]  cd_cnt  [NW];

  logic [WW-1:0]  cw;
  logic           upd;
  logic [PCW-1:0] c_pc   [3];
  logic [DPW-1:0] c_dep  [3];
  logic [NT-1:0]  c_mask [3];
  logic [PCW-1:0] s_pc   [3];
  logic [DPW-1:0] s_dep  [3];
  logic [NT-1:0]  s_mask [3];
  logic [1:0]     cmp_cnt;
  logic [CW-1:0]  pop_ix;
  logic [TW-1:0]  pop_sl, push_sl;
  logic           swap_v;
  logic [WW-1:0]  swap_warp;
  logic [TW-1:0]  swap_idx;

  assign cw  = commit_warp_i;
  assign upd = commit_valid_i && (commit_pc_i == h1_pc[cw]) && (h1_mask[cw] != '0);
  assign commit_mask_o = upd ? h1_mask[cw] : '0;

  assign c_pc[0]   = h2_pc[cw];
  assign c_dep[0]  = h2_dep[cw];
  assign c_mask[0] = h2_mask[cw];
  assign c_pc[1]   = seq_pc_i;
  assign c_dep[1]  = seq_dep_i;
  assign c_mask[1] = seq_mask_i & commit_mask_o;
  assign c_pc[2]   = alt_pc_i;
  assign c_dep[2]  = alt_dep_i;
  assign c_mask[2] = alt_mask_i & commit_mask_o;

  assign pop_ix  = cd_cnt[cw] - CW'(1);
  assign pop_sl  = pop_ix[TW-1:0];
  assign push_sl = cd_cnt[cw][TW-1:0];

  simt_trk_compact #(.NT(NT), .PCW(PCW), .DPW(DPW)) i_compact (
    .c_pc_i  (c_pc),
    .c_dep_i (c_dep),
    .c_mask_i(c_mask),
    .s_pc_o  (s_pc),
    .s_dep_o (s_dep),
    .s_mask_o(s_mask),
    .cnt_o   (cmp_cnt)
  );

  simt_trk_leader #(.NT(NT), .TW(TW)) i_leader (
    .mask_i(commit_mask_o),
    .idx_o (leader_o),
    .vld_o (leader_valid_o)
  );

  simt_trk_sorter #(
    .NW(NW), .NT(NT), .PCW(PCW), .DPW(DPW), .WW(WW), .TW(TW), .CW(CW)
  ) i_sorter (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cnt_i      (cd_cnt),
    .h2_pc_i    (h2_pc),
    .h2_dep_i   (h2_dep),
    .h2_mask_i  (h2_mask),
    .cd_pc_i    (cd_pc),
    .cd_dep_i   (cd_dep),
    .upd_i      (upd),
    .upd_warp_i (cw),
    .swap_o     (swap_v),
    .swap_warp_o(swap_warp),
    .swap_idx_o (swap_idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int w = 0; w < NW; w++) begin
        h1_pc[w]   <= PCW'(RESET_PC);
        h1_dep[w]  <= '0;
        h1_mask[w] <= '1;
        h2_pc[w]   <= '0;
        h2_dep[w]  <= '0;
        h2_mask[w] <= '0;
        cd_cnt[w]  <= '0;
        for (int e = 0; e < NT; e++) begin
          cd_pc[w][e]   <= '0;
          cd_dep[w][e]  <= '0;
          cd_mask[w][e] <= '0;
        end
      end
    end else begin
      if (upd) begin
        h1_pc[cw]   <= s_pc[0];
        h1_dep[cw]  <= s_dep[0];
        h1_mask[cw] <= s_mask[0];
        if (cmp_cnt <= 2'd1) begin
          if (cd_cnt[cw] != '0) begin
            h2_pc[cw]   <= cd_pc[cw][pop_sl];
            h2_dep[cw]  <= cd_dep[cw][pop_sl];
            h2_mask[cw] <= cd_mask[cw][pop_sl];
            cd_cnt[cw]  <= pop_ix;
          end else begin
            h2_mask[cw] <= '0;
          end
        end else begin
          h2_pc[cw]   <= s_pc[1];
          h2_dep[cw]  <= s_dep[1];
          h2_mask[cw] <= s_mask[1];
          if (cmp_cnt == 2'd3) begin
            cd_pc[cw][push_sl]   <= s_pc[2];
            cd_dep[cw][push_sl]  <= s_dep[2];
            cd_mask[cw][push_sl] <= s_mask[2];
            cd_cnt[cw]           <= cd_cnt[cw] + 1'b1;
          end
        end
      end
      // sorter never targets the committing warp
      if (swap_v) begin
        h2_pc[swap_warp]             <= cd_pc[swap_warp][swap_idx];
        h2_dep[swap_warp]            <= cd_dep[swap_warp][swap_idx];
        h2_mask[swap_warp]           <= cd_mask[swap_warp][swap_idx];
        cd_pc[swap_warp][swap_idx]   <= h2_pc[swap_warp];
        cd_dep[swap_warp][swap_idx]  <= h2_dep[swap_warp];
        cd_mask[swap_warp][swap_idx] <= h2_mask[swap_warp];
      end
    end
  end

  assign act_pc_o   = h1_pc[query_warp_i];
  assign act_dep_o  = h1_dep[query_warp_i];
  assign act_mask_o = h1_mask[query_warp_i];
  assign sec_pc_o   = h2_pc[query_warp_i];
  assign sec_dep_o  = h2_dep[query_warp_i];
  assign sec_mask_o = h2_mask[query_warp_i];

endmodule

// File: rtl/simt_trk_chk.sv
module simt_trk_chk #(
  parameter int unsigned NW  = 4,
  parameter int unsigned NT  = 4,
  parameter int unsigned PCW = 16,
  parameter int unsigned WW  = 2,
  parameter int unsigned TW  = 2,
  parameter int unsigned CW  = 3
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           commit_valid_i,
  input logic [WW-1:0]  commit_warp_i,
  input logic [NT-1:0]  commit_mask_o,
  input logic [TW-1:0]  leader_o,
  input logic           leader_valid_o,
  input logic [NT-1:0]  act_mask_o,
  input logic [NT-1:0]  sec_mask_o,
  input logic           upd,
  input logic [1:0]     cmp_cnt,
  input logic [CW-1:0]  cd_cnt  [NW],
  input logic [PCW-1:0] h1_pc   [NW],
  input logic [NT-1:0]  h1_mask [NW],
  input logic           swap_v,
  input logic [WW-1:0]  swap_warp
);

  logic [NT-1:0] below_leader;
  always_comb begin
    below_leader = '0;
    for (int i = 0; i < NT; i++) if (i < int'(leader_o)) below_leader[i] = 1'b1;
  end

  // R3: leader bit is set and no lower bit is set
  a_r3_leader_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    leader_valid_o |-> commit_mask_o[leader_o]);
  a_r3_leader_lowest: assert property (@(posedge clk_i) disable iff (!rst_ni)
    leader_valid_o |-> ((commit_mask_o & below_leader) == '0));

  // R2: a commit with no committing thread leaves the active stream as it was
  a_r2_no_commit_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_valid_i && commit_mask_o == '0) |=>
      (h1_mask[$past(commit_warp_i)] == $past(h1_mask[commit_warp_i])) &&
      (h1_pc[$past(commit_warp_i)] == $past(h1_pc[commit_warp_i])));

  // R7: three survivors grow the cold stack by one
  a_r7_push: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd && cmp_cnt == 2'd3) |=>
      cd_cnt[$past(commit_warp_i)] == CW'($past(cd_cnt[commit_warp_i]) + 1'b1));

  // R6: a single survivor pops a nonempty cold stack
  a_r6_pop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd && cmp_cnt <= 2'd1 && cd_cnt[commit_warp_i] != '0) |=>
      cd_cnt[$past(commit_warp_i)] == CW'($past(cd_cnt[commit_warp_i]) - 1'b1));

  // R8: sorter yields to a commit on the same warp
  a_r8_yield: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swap_v |-> !(upd && commit_warp_i == swap_warp));

  // R9: hot streams never share a thread
  a_r9_disjoint: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_mask_o & sec_mask_o) == '0);

  for (genvar g = 0; g < NW; g++) begin : g_bound
    // R6/R7: cold stack stays within its thread-count capacity
    a_r7_cold_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cd_cnt[g] <= CW'(NT));
  end

endmodule

bind simt_stream_tracker simt_trk_chk #(
  .NW(NW), .NT(NT), .PCW(PCW), .WW(WW), .TW(TW), .CW(CW)
) i_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .commit_valid_i(commit_valid_i),
  .commit_warp_i (commit_warp_i),
  .commit_mask_o (commit_mask_o),
  .leader_o      (leader_o),
  .leader_valid_o(leader_valid_o),
  .act_mask_o    (act_mask_o),
  .sec_mask_o    (sec_mask_o),
  .upd           (upd),
  .cmp_cnt       (cmp_cnt),
  .cd_cnt        (cd_cnt),
  .h1_pc         (h1_pc),
  .h1_mask       (h1_mask),
  .swap_v        (swap_v),
  .swap_warp     (swap_warp)
);

// File: tb/test_simt_stream_tracker.sv
module test_simt_stream_tracker;
  localparam int CLK_P = 10;
  localparam int NW = 4;
  localparam int NT = 4;
  localparam int FULL = (1 << NT) - 1;
  localparam int SINK = 'h100;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        commit_valid_i = 1'b0;
  logic [1:0]  commit_warp_i = '0;
  logic [15:0] commit_pc_i = '0;
  logic [15:0] seq_pc_i = '0, alt_pc_i = '0;
  logic [2:0]  seq_dep_i = '0, alt_dep_i = '0;
  logic [3:0]  seq_mask_i = '0, alt_mask_i = '0;
  logic [3:0]  commit_mask_o;
  logic [1:0]  leader_o;
  logic        leader_valid_o;
  logic [1:0]  query_warp_i = '0;
  logic [15:0] act_pc_o, sec_pc_o;
  logic [2:0]  act_dep_o, sec_dep_o;
  logic [3:0]  act_mask_o, sec_mask_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;
  int mpc [NW][NT];
  int mdp [NW][NT];

  always #(CLK_P/2) clk_i = ~clk_i;

  simt_stream_tracker #(.NW(NW), .NT(NT), .PCW(16), .DPW(3), .RESET_PC(0)) i_simt_stream_tracker (
    .clk_i, .rst_ni, .commit_valid_i, .commit_warp_i, .commit_pc_i,
    .seq_pc_i, .seq_dep_i, .seq_mask_i, .alt_pc_i, .alt_dep_i, .alt_mask_i,
    .commit_mask_o, .leader_o, .leader_valid_o, .query_warp_i,
    .act_pc_o, .act_dep_o, .act_mask_o, .sec_pc_o, .sec_dep_o, .sec_mask_o
  );

  task automatic chk(string tag, int got, int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  // R9: hot streams consistent with per-thread model
  task automatic check_hot(int w);
    query_warp_i = 2'(w);
    #1;
    chk("R9 active nonempty", int'(act_mask_o != 0), 1);
    chk("R9 disjoint", int'(act_mask_o & sec_mask_o), 0);
    for (int t = 0; t < NT; t++) begin
      if (act_mask_o[t]) begin
        chk("R9 active pc", int'(act_pc_o), mpc[w][t]);
        chk("R9 active dep", int'(act_dep_o), mdp[w][t]);
      end
      if (sec_mask_o[t]) begin
        chk("R9 second pc", int'(sec_pc_o), mpc[w][t]);
        chk("R9 second dep", int'(sec_dep_o), mdp[w][t]);
      end
    end
  endtask

  task automatic chk_hot(string tag, int w, int apc, int adp, int amk, int spc, int sdp, int smk);
    query_warp_i = 2'(w);
    #1;
    chk({tag, " act mask"}, int'(act_mask_o), amk);
    if (amk != 0) begin
      chk({tag, " act pc"}, int'(act_pc_o), apc);
      chk({tag, " act dep"}, int'(act_dep_o), adp);
    end
    chk({tag, " sec mask"}, int'(sec_mask_o), smk);
    if (smk != 0) begin
      chk({tag, " sec pc"}, int'(sec_pc_o), spc);
      chk({tag, " sec dep"}, int'(sec_dep_o), sdp);
    end
  endtask

  // called just after a falling edge
  task automatic commit(int w, int pc, int spc, int sdp, int smk, int apc, int adp, int amk);
    int exp_m;
    int exp_l;
    query_warp_i   = 2'(w);
    commit_valid_i = 1'b1;
    commit_warp_i  = 2'(w);
    commit_pc_i    = 16'(pc);
    seq_pc_i = 16'(spc); seq_dep_i = 3'(sdp); seq_mask_i = 4'(smk);
    alt_pc_i = 16'(apc); alt_dep_i = 3'(adp); alt_mask_i = 4'(amk);
    #1;
    exp_m = (pc == int'(act_pc_o)) ? int'(act_mask_o) : 0;
    exp_l = 0;
    for (int t = NT - 1; t >= 0; t--) if (exp_m[t]) exp_l = t;
    chk("R2 commit mask", int'(commit_mask_o), exp_m);
    chk("R3 leader valid", int'(leader_valid_o), int'(exp_m != 0));
    if (exp_m != 0) chk("R3 leader index", int'(leader_o), exp_l);
    @(posedge clk_i);
    #1;
    commit_valid_i = 1'b0;
    for (int t = 0; t < NT; t++) begin
      if (exp_m[t]) begin
        if (amk[t]) begin mpc[w][t] = apc; mdp[w][t] = adp; end
        else if (smk[t]) begin mpc[w][t] = spc; mdp[w][t] = sdp; end
      end
    end
    check_hot(w);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int p, d, m, tk, ad, spc;
    for (int w = 0; w < NW; w++)
      for (int t = 0; t < NT; t++) begin mpc[w][t] = 0; mdp[w][t] = 0; end
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R1, R10: reset state per warp through the query port
    for (int w = 0; w < NW; w++) chk_hot("R1 R10 reset", w, 0, 0, FULL, 0, 0, 0);

    // R4 R6: divergence then reconvergence, empty cold stack leaves second empty
    @(negedge clk_i);
    commit(0, 0, 4, 0, 'b1100, 'h20, 0, 'b0011);
    chk_hot("R5 split", 0, 4, 0, 'b1100, 'h20, 0, 'b0011);
    for (int pc = 4; pc < 'h20; pc += 4) begin
      @(negedge clk_i);
      commit(0, pc, pc + 4, 0, 'b1100, 0, 0, 0);
    end
    chk_hot("R4 merge", 0, 'h20, 0, FULL, 0, 0, 0);

    // R5 R7 R6: three survivors push, single survivor pops
    @(negedge clk_i);
    commit(1, 0, 4, 0, 'b0011, 'h30, 0, 'b1100);
    @(negedge clk_i);
    commit(1, 4, 8, 0, 'b0001, 'h10, 1, 'b0010);
    chk_hot("R5 R7 push", 1, 'h10, 1, 'b0010, 8, 0, 'b0001);
    @(negedge clk_i);
    commit(1, 'h10, 8, 0, 'b0010, 0, 0, 0);
    chk_hot("R4 R6 pop", 1, 8, 0, 'b0011, 'h30, 0, 'b1100);

    // R8: build a cold entry that outranks the second stream, then idle
    @(negedge clk_i);
    commit(2, 0, 4, 0, 'b0011, 'h20, 0, 'b1100);
    @(negedge clk_i);
    commit(2, 4, 'h30, 0, 'b0001, 8, 0, 'b0010);
    chk_hot("R7 push2", 2, 8, 0, 'b0010, 'h20, 0, 'b1100);
    @(negedge clk_i);
    commit(2, 8, 'h38, 0, 'b0010, 0, 0, 0);
    repeat (40) @(negedge clk_i);
    chk_hot("R8 sorter swap", 2, 'h20, 0, 'b1100, 'h30, 0, 'b0001);
    check_hot(2);

    // R5 depth rank, R2 mismatched pc ignored
    @(negedge clk_i);
    commit(3, 0, 4, 0, 'b0011, 'h38, 1, 'b1100);
    chk_hot("R5 deeper wins", 3, 'h38, 1, 'b1100, 4, 0, 'b0011);
    @(negedge clk_i);
    commit(3, 'h10, 'h14, 0, 'b1100, 0, 0, 0);
    chk_hot("R2 ignored", 3, 'h38, 1, 'b1100, 4, 0, 'b0011);

    // R9: random divergence against per-thread model
    for (int n = 0; n < 3000; n++) begin
      int w;
      @(negedge clk_i);
      w = int'($urandom % NW);
      query_warp_i = 2'(w);
      #1;
      p = int'(act_pc_o); d = int'(act_dep_o); m = int'(act_mask_o);
      tk = m & int'($urandom % 16);
      ad = d + int'($urandom % 3) - 1;
      if (ad < 0) ad = 0;
      if (ad > 3) ad = 3;
      spc = (p + 4) % 64;
      commit(w, p, spc, d, m & ~tk, int'($urandom % 16) * 4, ad, tk);
    end

    // R9: drain everything to one PC; no thread may be missing
    for (int w = 0; w < NW; w++) begin
      for (int k = 0; k < 60; k++) begin
        @(negedge clk_i);
        query_warp_i = 2'(w);
        #1;
        if (int'(act_mask_o) == FULL && int'(act_pc_o) == SINK && sec_mask_o == 0) break;
        commit(w, int'(act_pc_o), SINK, 0, int'(act_mask_o), 0, 0, 0);
      end
      chk_hot("R9 drain", w, SINK, 0, FULL, 0, 0, 0);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule